// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls one bidirectional port of `W` pins. Software writes an output latch, a per-pin input-mode mask (digital or analog) and a per-pin drive-mode mask (push-pull or open-drain) through a small synchronous register bus. A control register holds one global bit that turns the weak pullups off. From these settings the block derives three registered per-pin signals for the pad ring: output enable, output value and pullup enable.

Sampled pad levels come in on `pin_i`. They pass through a synchroniser before any read sees them. A read of the data register returns those conditioned levels and never the latch. Any pin set to analog reads back as zero. An override request with its own data byte stands in for a peripheral that owns some pins. For each pin it claims, it replaces the latch.

Register addresses are 0 for the data latch, 1 for input mode, 2 for drive mode and 3 for control. In the control register only bit 0 is implemented, as the pullup disable.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the latch and the input-mode mask read back all ones, the drive-mode mask reads all zeros (open-drain), the control register reads 0, and the outputs are oe_o=0, out_o=all ones, pu_o=all ones.
- R2: The effective bit of a pin is 0 when the latch bit (or, for a claimed pin, the override data bit) is 0. Such a pin is driven, with oe_o=1 and out_o=0.
- R3: An effective bit of 1 gives oe_o=1 and out_o=1 when the pin's drive-mode bit is 1 (push-pull). It gives oe_o=0 (pin released) when that bit is 0 (open-drain).
- R4: A read of address 0 returns the synchronised pin levels, not the latch. A level applied to pin_i appears after two synchroniser stages plus the read register.
- R5: For a pin whose input-mode bit is 0 (analog), the address-0 read bit is always 0.
- R6: A pin in analog mode has pu_o=0 whatever the global pullup-disable bit holds.
- R7: A digital-mode pin that is not driven low has pu_o equal to the inverse of control bit 0.
- R8: Any pin that is being driven low has pu_o=0.
- R9: For a pin whose ovr_en_i bit is 1, ovr_data_i replaces the latch bit in the drive decision. The outputs follow one clock after the override inputs change.
- R10: Addresses 1, 2 and 3 read back the last value written. Bits 7 to 1 of address 3 read 0.
- R11: An analog-mode pin still drives according to its latch and drive-mode bits.
- R12: A register write shows on oe_o, out_o and pu_o two clock edges after the write is sampled, and not on the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Registered read data, valid one clock after rd_en_i |
| pin_i | input | W | Sampled pad levels (asynchronous) |
| ovr_en_i | input | W | Per-pin override claim |
| ovr_data_i | input | W | Override drive data |
| oe_o | output | W | Per-pin output enable |
| out_o | output | W | Per-pin output value |
| pu_o | output | W | Per-pin weak pullup enable |

## Verification
A register write lands at the sampling edge and reaches the pad outputs at the next edge. The bench therefore compares outputs at the second falling edge after the write. It also checks once, directly, that the first falling edge still shows the old value. An override change needs only the output register, so the bench checks it at the first falling edge. A change on `pin_i` is allowed three edges (two synchroniser stages and the read register) before a data read is issued, so every read sees a settled level. Expected values come from bench copies of the registers after each write.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    REG_LATCH   = 2'd0,
    REG_INMODE  = 2'd1,
    REG_DRVMODE = 2'd2,
    REG_CTRL    = 2'd3
  } gpio_reg_e;

  localparam int CTRL_PUDIS_BIT = 0;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] latch_o,
  output logic [W-1:0] in_mode_o,
  output logic [W-1:0] drv_mode_o,
  output logic         pu_dis_o
);

  gpio_reg_e sel;
  assign sel = gpio_reg_e'(addr_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      latch_o    <= '1;
      in_mode_o  <= '1;
      drv_mode_o <= '0;
      pu_dis_o   <= 1'b0;
    end else if (wr_en_i) begin
      case (sel)
        REG_LATCH:   latch_o    <= wdata_i;
        REG_INMODE:  in_mode_o  <= wdata_i;
        REG_DRVMODE: drv_mode_o <= wdata_i;
        REG_CTRL:    pu_dis_o   <= wdata_i[CTRL_PUDIS_BIT];
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) chain[0] <= '0;
    else       chain[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (rst_i) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] latch_i,
  input  logic [W-1:0] in_mode_i,
  input  logic [W-1:0] drv_mode_i,
  input  logic         pu_dis_i,
  input  logic [W-1:0] ovr_en_i,
  input  logic [W-1:0] ovr_data_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] pu_o
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic want_hi;
    logic drive_lo;
    logic drive_hi;
    logic oe_n, out_n, pu_n;

    always_comb begin
      want_hi  = ovr_en_i[i] ? ovr_data_i[i] : latch_i[i];
      drive_lo = ~want_hi;
      drive_hi = want_hi & drv_mode_i[i];
      oe_n     = drive_lo | drive_hi;
      out_n    = want_hi;
      pu_n     = in_mode_i[i] & ~pu_dis_i & ~drive_lo;
    end

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        oe_o[i]  <= 1'b0;
        out_o[i] <= 1'b1;
        pu_o[i]  <= 1'b1;
      end else begin
        oe_o[i]  <= oe_n;
        out_o[i] <= out_n;
        pu_o[i]  <= pu_n;
      end
    end
  end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         rd_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] pins_sync_i,
  input  logic [W-1:0] in_mode_i,
  input  logic [W-1:0] drv_mode_i,
  input  logic         pu_dis_i,
  output logic [W-1:0] rdata_o
);

  logic [W-1:0] nxt;

  always_comb begin
    nxt = '0;
    case (gpio_reg_e'(addr_i))
      REG_LATCH:   nxt = pins_sync_i & in_mode_i;
      REG_INMODE:  nxt = in_mode_i;
      REG_DRVMODE: nxt = drv_mode_i;
      REG_CTRL:    nxt[CTRL_PUDIS_BIT] = pu_dis_i;
      default:     nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        rdata_o <= '0;
    else if (rd_en_i) rdata_o <= nxt;
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         wr_en_i,
  input  logic         rd_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] ovr_en_i,
  input  logic [W-1:0] ovr_data_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] pu_o
);

  logic [W-1:0] latch_q, in_mode_q, drv_mode_q, pins_sync;
  logic         pu_dis_q;

  gpio_port_regs #(.W(W)) u_regs (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .latch_o    (latch_q),
    .in_mode_o  (in_mode_q),
    .drv_mode_o (drv_mode_q),
    .pu_dis_o   (pu_dis_q)
  );

  gpio_pin_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (pin_i),
    .q_o   (pins_sync)
  );

  gpio_pin_drive #(.W(W)) u_drive (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .latch_i    (latch_q),
    .in_mode_i  (in_mode_q),
    .drv_mode_i (drv_mode_q),
    .pu_dis_i   (pu_dis_q),
    .ovr_en_i   (ovr_en_i),
    .ovr_data_i (ovr_data_i),
    .oe_o       (oe_o),
    .out_o      (out_o),
    .pu_o       (pu_o)
  );

  gpio_read_mux #(.W(W)) u_rd (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .rd_en_i     (rd_en_i),
    .addr_i      (addr_i),
    .pins_sync_i (pins_sync),
    .in_mode_i   (in_mode_q),
    .drv_mode_i  (drv_mode_q),
    .pu_dis_i    (pu_dis_q),
    .rdata_o     (rdata_o)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         rd_en_i,
  input logic [1:0]   addr_i,
  input logic [W-1:0] rdata_o,
  input logic [W-1:0] in_mode_q,
  input logic [W-1:0] ovr_en_i,
  input logic [W-1:0] ovr_data_i,
  input logic [W-1:0] oe_o,
  input logic [W-1:0] out_o,
  input logic [W-1:0] pu_o
);

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    $fell(rst_i) |-> (oe_o == '0 && out_o == '1 && pu_o == '1));

  // R8
  no_pullup_on_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ((oe_o & ~out_o & pu_o) == '0));

  // R9
  ovr_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ((ovr_en_i & ~ovr_data_i) != '0) |=>
      ((oe_o & ~out_o & $past(ovr_en_i & ~ovr_data_i)) == $past(ovr_en_i & ~ovr_data_i)));

  // R9
  ovr_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ((ovr_en_i & ovr_data_i) != '0) |=>
      ((out_o & $past(ovr_en_i & ovr_data_i)) == $past(ovr_en_i & ovr_data_i)));

  // R6
  analog_no_pullup_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_mode_q != '1) |=> ((pu_o & ~$past(in_mode_q)) == '0));

  // R5
  analog_reads_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_en_i && addr_i == 2'd0) |=> ((rdata_o & ~$past(in_mode_q)) == '0));

endmodule

bind gpio_port_ctrl gpio_port_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .in_mode_q  (in_mode_q),
  .ovr_en_i   (ovr_en_i),
  .ovr_data_i (ovr_data_i),
  .oe_o       (oe_o),
  .out_o      (out_o),
  .pu_o       (pu_o)
);

// File: tb/tb_gpio_port_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_port_ctrl;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]   addr = '0;
  logic [W-1:0] wdata = '0, pins = '0, oven = '0, ovd = '0;
  logic [W-1:0] rdata, oe, outv, pu;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [W-1:0] m_latch, m_imode, m_dmode;
  logic         m_pudis;

  always #2.5 clk = ~clk;

  gpio_port_ctrl #(.W(W)) dut (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins),
    .ovr_en_i(oven), .ovr_data_i(ovd), .oe_o(oe), .out_o(outv), .pu_o(pu)
  );

  function automatic logic [W-1:0] eff_bits();
    return (oven & ovd) | (~oven & m_latch);
  endfunction
  function automatic logic [W-1:0] exp_oe();
    return ~eff_bits() | m_dmode;
  endfunction
  function automatic logic [W-1:0] exp_pu();
    return m_pudis ? '0 : (m_imode & eff_bits());
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    case (a)
      2'd0: m_latch = d;
      2'd1: m_imode = d;
      2'd2: m_dmode = d;
      default: m_pudis = d[0];
    endcase
  endtask

  task automatic rd(logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic check_outs(string tag);
    check({tag, " oe"},  oe,   exp_oe());
    check({tag, " out"}, outv, eff_bits());
    check({tag, " pu"},  pu,   exp_pu());
  endtask

  task automatic set_pins(logic [W-1:0] v);
    @(negedge clk); pins = v;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r;
    void'($urandom(32'hC0FFEE));
    m_latch = '1; m_imode = '1; m_dmode = '0; m_pudis = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 oe", oe, '0);
    check("R1 out", outv, '1);
    check("R1 pu", pu, '1);
    rd(2'd1, r); check("R1 inmode", r, '1);
    rd(2'd2, r); check("R1 drvmode", r, '0);
    rd(2'd3, r); check("R1 ctrl", r, '0);

    // R12 latency, R2 drive low, R8
    wr(2'd0, 8'h00);
    check("R12 old oe", oe, '0);
    @(negedge clk);
    check("R2 oe", oe, '1);
    check("R2 out", outv, '0);
    check("R8 pu", pu, '0);

    // R3 open-drain vs push-pull
    wr(2'd0, 8'hF0); @(negedge clk);
    check("R3 open-drain oe", oe, 8'h0F);
    wr(2'd2, 8'h30); @(negedge clk);
    check("R3 push-pull oe", oe, 8'h3F);
    check_outs("R3");

    // R4 reads pins not latch
    set_pins(8'hA5);
    rd(2'd0, r); check("R4 pins", r, 8'hA5);

    // R5 / R6 / R11 analog pins
    wr(2'd1, 8'h0F); @(negedge clk);
    rd(2'd0, r); check("R5 analog zero", r, 8'h05);
    check("R6 pu", pu, 8'h00);
    check("R11 oe", oe, 8'h3F);
    wr(2'd0, 8'hFF); @(negedge clk);
    check("R6 pu", pu, 8'h0F);

    // R7 global disable
    wr(2'd3, 8'hFF); @(negedge clk);
    check("R7 pu off", pu, 8'h00);
    rd(2'd3, r); check("R10 ctrl", r, 8'h01);
    wr(2'd3, 8'h00); @(negedge clk);
    check("R7 pu on", pu, 8'h0F);

    // R9 override, one-cycle latency
    @(negedge clk); oven = 8'hC3; ovd = 8'h41;
    @(negedge clk);
    check_outs("R9");

    // R10 readback
    wr(2'd2, 8'h5A); rd(2'd2, r); check("R10 drvmode", r, 8'h5A);
    wr(2'd1, 8'hB6); rd(2'd1, r); check("R10 inmode", r, 8'hB6);

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [W-1:0] v;
      v = W'($urandom);
      case ($urandom % 6)
        0: wr(2'd0, v);
        1: wr(2'd1, v);
        2: wr(2'd2, v);
        3: wr(2'd3, v);
        4: begin @(negedge clk); oven = W'($urandom) & W'($urandom); ovd = v; end
        default: begin @(negedge clk); pins = v; end
      endcase
      repeat (3) @(negedge clk);
      check_outs("R2/R3/R6/R7/R8/R9 random");
      rd(2'd0, r); check("R4/R5 random read", r, pins & m_imode);
      rd(2'd1, r); check("R10 random inmode", r, m_imode);
      rd(2'd3, r); check("R10 random ctrl", r, {{(W-1){1'b0}}, m_pudis});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule